// File: doc/BRIEF.md
# Interleaved Dual-Converter Start Scheduler

This block paces two sampling converters that share one regular input channel in interleaved fashion. An external trigger arrives through the first (master) converter's regular trigger path. When the mode field selects interleaving, the block issues a master start immediately. It then waits for the master to report the end of its sampling window and holds the second (slave) converter back for a programmable guard interval. Only after that interval does it release the slave start. The guard interval is counted from half a converter clock after the master's sampling ends, not from the trigger.

The block runs on a clock at twice the converter clock, so one register stage equals half a converter cycle. The 4-bit delay field selects a guard of (field + 1) converter cycles, which is 2·(field + 1) half-steps. The field is captured when a trigger is accepted. When both converters have reported completion, in either order, the block emits a one-cycle pair-complete pulse and returns to idle. Triggers that arrive in the meantime are dropped.

Top module: `ilv_start_sched`

## Requirements
- R1: While `rstN` is low, and right after its release, `mstStart`, `slvStart`, `pairDone` and `busy` are all 0.
- R2: A trigger is accepted only when `modeCode` equals 5'b00111. With any other code, a trigger produces no `mstStart` and leaves `busy` at 0.
- R3: When an idle block samples `trigIn` high at a rising edge with the mode enabled, `mstStart` is high for exactly the following clock cycle.
- R4: Let edge t0 be the rising edge at which `mstEos` is sampled high. `slvStart` is then high for exactly one cycle, starting at edge t0 + 2·D + 3, where D is the captured delay field. This equals a half-step offset plus 2·(D+1) half-steps.
- R5: The delay field is captured at the edge that accepts the trigger. Changes to `delayCfg` after that edge do not alter the slave start time of the running sequence.
- R6: While `busy` is high, further triggers are ignored. No additional `mstStart` pulse appears.
- R7: `pairDone` pulses high for one cycle after the edge at which the later of `mstDone` and `slvDone` is sampled. The two may arrive in either order or together, and `mstDone` may arrive during the guard interval.
- R8: `busy` rises at the edge that accepts a trigger and falls at the edge that raises `pairDone`.
- R9: `slvStart` is never issued before `mstEos` has been sampled, however long the master's sampling lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter clock rate (half-step clock) |
| rstN | input | 1 | Active-low synchronous reset |
| modeCode | input | 5 | Pairing mode field; 5'b00111 enables interleaving |
| delayCfg | input | 4 | Guard interval field D; guard = (D+1) converter cycles |
| trigIn | input | 1 | Regular trigger from the master's trigger selection |
| mstEos | input | 1 | Master end-of-sampling pulse |
| mstDone | input | 1 | Master conversion complete pulse |
| slvDone | input | 1 | Slave conversion complete pulse |
| mstStart | output | 1 | One-cycle start command to the master |
| slvStart | output | 1 | One-cycle start command to the slave |
| pairDone | output | 1 | One-cycle pulse once both conversions finished |
| busy | output | 1 | High while a pair sequence is in progress |

## Verification
The bench builds the block with its default widths: a 5-bit mode field with code 5'b00111 and a 4-bit delay field. The full guard range from 2 to 32 half-steps can therefore be reached, including the D=0 and D=15 endpoints as directed cases. Random sequences vary the master sampling length, the arrival of `mstDone` relative to the guard window and the slave start, and the stray triggers and delay-field changes injected mid-sequence. Every slave start and pair-complete edge is predicted from the captured D.

// File: rtl/ilv_sched_pkg.sv
package ilv_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_OFFSET,
    ST_COUNT,
    ST_CONV
  } schedState_t;

  typedef struct packed {
    logic captureCfg;
    logic clrFlags;
    logic loadCnt;
    logic decCnt;
  } dpStrobe_t;

endpackage

// File: rtl/ilv_sched_dp.sv
module ilv_sched_dp
  import ilv_sched_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [DLY_W-1:0] delayCfg,
  input  logic             mstDone,
  input  logic             slvDone,
  output logic             cntZero,
  output logic             bothDone
);

  localparam int CNT_W = DLY_W + 1;

  logic [DLY_W-1:0] dlyReg;
  logic [CNT_W-1:0] cnt;
  logic             mstSeen;
  logic             slvSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlyReg <= '0;
    end else if (strobe.captureCfg) begin
      dlyReg <= delayCfg;
    end
  end

  // load 2*D+1: together with the zero-check edge this gives 2*(D+1) half-steps
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadCnt) begin
      cnt <= {dlyReg, 1'b1};
    end else if (strobe.decCnt) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrFlags) begin
      mstSeen <= 1'b0;
      slvSeen <= 1'b0;
    end else begin
      if (mstDone) mstSeen <= 1'b1;
      if (slvDone) slvSeen <= 1'b1;
    end
  end

  assign cntZero  = (cnt == '0);
  assign bothDone = (mstSeen | mstDone) & (slvSeen | slvDone);

  assert_no_underflow_R4 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.decCnt |-> (cnt != '0));

  assert_load_excl_R4 : assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadCnt && strobe.decCnt));

endmodule

// File: rtl/ilv_sched_ctrl.sv
module ilv_sched_ctrl
  import ilv_sched_pkg::*;
#(
  parameter int                MODE_W    = 5,
  parameter logic [MODE_W-1:0] MODE_CODE = 5'b00111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeCode,
  input  logic              trigIn,
  input  logic              mstEos,
  input  logic              cntZero,
  input  logic              bothDone,
  output dpStrobe_t         strobe,
  output logic              mstStart,
  output logic              slvStart,
  output logic              pairDone,
  output logic              busy
);

  schedState_t state;
  schedState_t nextState;
  logic        accept;

  assign accept = (state == ST_IDLE) && trigIn && (modeCode == MODE_CODE);

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          strobe.captureCfg = 1'b1;
          strobe.clrFlags   = 1'b1;
          nextState         = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        if (mstEos) nextState = ST_OFFSET;
      end
      ST_OFFSET: begin
        strobe.loadCnt = 1'b1;
        nextState      = ST_COUNT;
      end
      ST_COUNT: begin
        if (cntZero) nextState = ST_CONV;
        else         strobe.decCnt = 1'b1;
      end
      ST_CONV: begin
        if (bothDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      mstStart <= 1'b0;
      slvStart <= 1'b0;
      pairDone <= 1'b0;
    end else begin
      state    <= nextState;
      mstStart <= accept;
      slvStart <= (state == ST_COUNT) && cntZero;
      pairDone <= (state == ST_CONV) && bothDone;
    end
  end

  assign busy = (state != ST_IDLE);

  assert_mode_gate_R2 : assert property (@(posedge clk) disable iff (!rstN)
    mstStart |-> ($past(modeCode) == MODE_CODE));

  assert_pulses_onehot_R3 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({mstStart, slvStart, pairDone}));

  assert_busy_drop_ignore_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !mstStart);

  assert_pair_ends_busy_R7 : assert property (@(posedge clk) disable iff (!rstN)
    pairDone |-> (!busy && $past(busy)));

  assert_busy_rise_R8 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> mstStart);

endmodule

// File: rtl/ilv_start_sched.sv
module ilv_start_sched
  import ilv_sched_pkg::*;
#(
  parameter int                MODE_W    = 5,
  parameter logic [MODE_W-1:0] MODE_CODE = 5'b00111,
  parameter int                DLY_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeCode,
  input  logic [DLY_W-1:0]  delayCfg,
  input  logic              trigIn,
  input  logic              mstEos,
  input  logic              mstDone,
  input  logic              slvDone,
  output logic              mstStart,
  output logic              slvStart,
  output logic              pairDone,
  output logic              busy
);

  dpStrobe_t strobe;
  logic      cntZero;
  logic      bothDone;

  ilv_sched_ctrl #(
    .MODE_W    (MODE_W),
    .MODE_CODE (MODE_CODE)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .modeCode (modeCode),
    .trigIn   (trigIn),
    .mstEos   (mstEos),
    .cntZero  (cntZero),
    .bothDone (bothDone),
    .strobe   (strobe),
    .mstStart (mstStart),
    .slvStart (slvStart),
    .pairDone (pairDone),
    .busy     (busy)
  );

  ilv_sched_dp #(
    .DLY_W (DLY_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .delayCfg (delayCfg),
    .mstDone  (mstDone),
    .slvDone  (slvDone),
    .cntZero  (cntZero),
    .bothDone (bothDone)
  );

  assert_no_slave_while_idle_R9 : assert property (@(posedge clk) disable iff (!rstN)
    slvStart |-> busy);

endmodule

// File: tb/ilv_start_sched_tb_top.sv
module ilv_start_sched_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] MODE_ON = 5'b00111;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] modeCode = MODE_ON;
  logic [3:0] delayCfg = '0;
  logic       trigIn = 1'b0;
  logic       mstEos = 1'b0;
  logic       mstDone = 1'b0;
  logic       slvDone = 1'b0;
  logic       mstStart, slvStart, pairDone, busy;

  int nVec  = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_start_sched dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .modeCode (modeCode),
    .delayCfg (delayCfg),
    .trigIn   (trigIn),
    .mstEos   (mstEos),
    .mstDone  (mstDone),
    .slvDone  (slvDone),
    .mstStart (mstStart),
    .slvStart (slvStart),
    .pairDone (pairDone),
    .busy     (busy)
  );

  function automatic int slvEdgeOf(int d);
    return 2 * d + 3;
  endfunction

  function automatic int pairEdgeOf(int mA, int sA);
    return ((mA > sA) ? mA : sA) + 1;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic runSeq(int d, int eosWait, int mA, int sAOff, bit noise);
    int slvEdge = slvEdgeOf(d);
    int sA      = slvEdge + sAOff;
    int pd      = pairEdgeOf(mA, sA);
    chk("R8 idle before trigger", busy, 1'b0);
    modeCode = MODE_ON;
    delayCfg = 4'(d);
    trigIn   = 1'b1;
    step();
    trigIn = 1'b0;
    chk("R3 master start pulse", mstStart, 1'b1);
    chk("R8 busy after accept", busy, 1'b1);
    chk("R9 no slave at trigger", slvStart, 1'b0);
    delayCfg = 4'($urandom);  // R5: late change must be ignored
    for (int i = 0; i < eosWait; i++) begin
      trigIn = noise & 1'($urandom);
      step();
      chk("R6 trigger ignored while sampling", mstStart, 1'b0);
      chk("R9 slave held before eos", slvStart, 1'b0);
      chk("R8 busy while sampling", busy, 1'b1);
    end
    trigIn = noise & 1'($urandom);
    mstEos = 1'b1;
    step();
    mstEos = 1'b0;
    chk("R6 trigger ignored at eos", mstStart, 1'b0);
    chk("R9 slave held at eos", slvStart, 1'b0);
    for (int k = 0; k < pd; k++) begin
      int kk = k + 1;
      mstDone = (k == mA);
      slvDone = (k == sA);
      trigIn  = noise & 1'($urandom);
      step();
      chk("R4 R5 slave start timing", slvStart, kk == slvEdge);
      chk("R7 pair complete timing", pairDone, kk == pd);
      chk("R8 busy span", busy, kk < pd);
      chk("R6 no restart while busy", mstStart, 1'b0);
    end
    mstDone = 1'b0;
    slvDone = 1'b0;
    trigIn  = 1'b0;
    step();
    chk("R7 pair pulse single cycle", pairDone, 1'b0);
    chk("R8 idle after pair", busy, 1'b0);
  endtask

  task automatic offModeTrig();
    logic [4:0] m;
    do m = 5'($urandom); while (m == MODE_ON);
    modeCode = m;
    trigIn   = 1'b1;
    step();
    trigIn = 1'b0;
    chk("R2 no master start when mode off", mstStart, 1'b0);
    chk("R2 stays idle when mode off", busy, 1'b0);
    step();
    chk("R2 still idle", busy, 1'b0);
    modeCode = MODE_ON;
  endtask

  initial begin
    void'($urandom(32'd4021));
    rstN = 1'b0;
    trigIn = 1'b1;
    repeat (3) step();
    chk("R1 mstStart in reset", mstStart, 1'b0);
    chk("R1 slvStart in reset", slvStart, 1'b0);
    chk("R1 pairDone in reset", pairDone, 1'b0);
    chk("R1 busy in reset", busy, 1'b0);
    trigIn = 1'b0;
    rstN = 1'b1;
    step();
    chk("R1 busy after release", busy, 1'b0);
    chk("R1 mstStart after release", mstStart, 1'b0);

    // directed corners
    runSeq(0, 0, 0, 0, 1'b0);      // minimum guard, master done immediately
    runSeq(15, 3, 40, 0, 1'b1);    // maximum guard, master finishes last
    runSeq(5, 1, 13, 0, 1'b0);     // both dones in the same cycle (13 = 2*5+3)
    runSeq(2, 12, 2, 3, 1'b1);     // long sampling, master done inside guard
    offModeTrig();

    for (int n = 0; n < 40; n++) begin
      int d = int'($urandom_range(15, 0));
      int e = int'($urandom_range(10, 0));
      int m = int'($urandom_range(2 * d + 8, 0));
      int s = int'($urandom_range(4, 0));
      runSeq(d, e, m, s, 1'($urandom));
      if (n % 8 == 0) offModeTrig();
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

endmodule